// File: doc/BRIEF.md
# I2S Clock and Format Generator

This block produces the timing strobes for a serial audio port from one reference clock. Software programs a format word that picks the master-clock divisor, the bit-clock divisor, the number of bit clocks per frame and whether the port drives its own bit and word clocks. The block turns these into three signals. `mclk_en` is a one-cycle strobe at the master-clock rate. `sclk_en` is a one-cycle strobe at the bit-clock rate. `lrclk` is the word-select level. The reference clock itself comes from outside the block.

Both divisor fields use a non-linear code: a few small odd divisors have reserved codes, and every other code stands for an even divisor. A frame counter advances once per word-select period. When it reaches a programmed match value it raises an interrupt flag.

The format word can only change while the clocks are halted. Software drops `clk_run`. The generator then runs to the end of the current frame, stops, and sets a stop-pending flag that software clears by writing 1. Only after that is a new format accepted. A word-size register and an oscillator-select field are stored and read back for the rest of the port. They do not change the generated timing.

Top module: `i2s_clkgen`

## Requirements
- R1: After reset every register reads 0, and `mclk_en`, `sclk_en`, `lrclk`, `port_drive` and `irq` are low.
- R2: The master-clock code sits in format bits [28:24]. Code 14 means divisor 1, code 13 means divisor 3, code 12 means divisor 5, and any other code c means divisor 2*(c+1). While running, `mclk_en` pulses once every divisor reference cycles.
- R3: The bit-clock code sits in format bits [23:20]. Code 8 means divisor 1, code 9 means divisor 3, and any other code c means divisor 2*(c+1). While running, a bit-clock strobe occurs once every that many master-clock strobes.
- R4: Format bits [18:16] equal to 010 give 32 bit clocks per frame, and every other value gives 64. `lrclk` is low for the first half of each frame and high for the second half, each half being half the bit clocks of the frame.
- R5: Format bit 19 selects master mode. When it is clear, `port_drive`, `sclk_en` and `lrclk` stay low while `mclk_en` still runs.
- R6: The frame counter (offset 0x40) increases by one at the end of every frame and can be loaded by a register write.
- R7: When the frame counter steps onto the value at offset 0x50, status bit 0 (offset 0x00) is set and `irq` goes high. Writing 1 to that bit clears it.
- R8: When `clk_run` is low, the generator stops at the end of the current frame. At that point status bit 24 is set and `irq` goes high, and `mclk_en` stays low afterwards. Writing 1 to bit 24 clears it.
- R9: A write to the format register (offset 0x10) is ignored while `clk_run` is high or the generator is still running.
- R10: Only the defined bits are stored. The format register keeps the bits of mask 0xDFFF0000, and the word-size register (offset 0x60) keeps the bits of mask 0x03030303. The oscillator field in format bits [31:30] has no effect on the timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_run | input | 1 | Clock enable; low requests a stop at the frame end |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| mclk_en | output | 1 | Master-clock strobe |
| sclk_en | output | 1 | Bit-clock strobe (master mode only) |
| lrclk | output | 1 | Word-select level (master mode only) |
| port_drive | output | 1 | High when the port drives its bit and word clocks |
| irq | output | 1 | OR of the match and stop-pending flags |

## Verification
The hardest situation to reach is the stop handshake. The stop only happens on a frame boundary, so the flag timing depends on where in the frame `clk_run` fell. The format can be rewritten only inside the narrow window after the stop. Every reconfiguration in the bench therefore goes through the same stop, clear, write and restart sequence. A fast setting (divisors of 1, 32 bits per frame) keeps frames at 32 cycles, so the bench can bound the stop latency and count the frames up to the match interrupt exactly.

// File: rtl/i2s_clkgen_pkg.sv
package i2s_clkgen_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int MDIV_W = 7;
  localparam int SDIV_W = 6;
  localparam int BPF_W  = 7;

  localparam logic [ADDR_W-1:0] A_STATUS = 8'h00;
  localparam logic [ADDR_W-1:0] A_FORMAT = 8'h10;
  localparam logic [ADDR_W-1:0] A_FCOUNT = 8'h40;
  localparam logic [ADDR_W-1:0] A_FMATCH = 8'h50;
  localparam logic [ADDR_W-1:0] A_WSIZE  = 8'h60;

  localparam int STAT_MATCH_BIT = 0;
  localparam int STAT_STOP_BIT  = 24;

  localparam logic [DATA_W-1:0] FORMAT_MASK = 32'hDFFF_0000;
  localparam logic [DATA_W-1:0] WSIZE_MASK  = 32'h0303_0303;

  localparam logic [2:0] FRAMING_32 = 3'b010;

  function automatic logic [MDIV_W-1:0] mclk_divisor(input logic [4:0] code);
    case (code)
      5'd14:   mclk_divisor = MDIV_W'(1);
      5'd13:   mclk_divisor = MDIV_W'(3);
      5'd12:   mclk_divisor = MDIV_W'(5);
      default: mclk_divisor = MDIV_W'({2'b00, code} + 7'd1) << 1;
    endcase
  endfunction

  function automatic logic [SDIV_W-1:0] sclk_divisor(input logic [3:0] code);
    case (code)
      4'd8:    sclk_divisor = SDIV_W'(1);
      4'd9:    sclk_divisor = SDIV_W'(3);
      default: sclk_divisor = SDIV_W'({2'b00, code} + 6'd1) << 1;
    endcase
  endfunction

  function automatic logic [BPF_W-1:0] bits_per_frame(input logic [2:0] framing);
    bits_per_frame = (framing == FRAMING_32) ? BPF_W'(32) : BPF_W'(64);
  endfunction
endpackage

// File: rtl/i2s_tick_div.sv
module i2s_tick_div #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick_in,
  input  logic [W-1:0] divisor,
  output logic         tick_out
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         at_last;

  assign at_last  = (cnt_q == divisor - W'(1));
  assign tick_out = run & tick_in & at_last;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)
      cnt_d = '0;
    else if (tick_in)
      cnt_d = at_last ? '0 : cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/i2s_frame_seq.sv
module i2s_frame_seq
  import i2s_clkgen_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             bit_tick,
  input  logic [BPF_W-1:0] bpf,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic [CNT_W-1:0] match_val,
  output logic             lrclk,
  output logic             frame_end,
  output logic [CNT_W-1:0] frame_cnt,
  output logic             match_hit
);
  logic [BPF_W-1:0] bit_q, bit_d;
  logic [CNT_W-1:0] fcnt_q, fcnt_d;
  logic [CNT_W-1:0] fcnt_inc;

  assign frame_end = run & bit_tick & (bit_q == bpf - BPF_W'(1));
  assign lrclk     = (bit_q >= (bpf >> 1));
  assign fcnt_inc  = fcnt_q + CNT_W'(1);
  assign match_hit = frame_end & ~cnt_wr & (fcnt_inc == match_val);
  assign frame_cnt = fcnt_q;

  always_comb begin
    bit_d = bit_q;
    if (!run)
      bit_d = '0;
    else if (bit_tick)
      bit_d = frame_end ? '0 : bit_q + BPF_W'(1);
  end

  always_comb begin
    fcnt_d = fcnt_q;
    if (cnt_wr)
      fcnt_d = cnt_wdata;
    else if (frame_end)
      fcnt_d = fcnt_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q  <= '0;
      fcnt_q <= '0;
    end else begin
      bit_q  <= bit_d;
      fcnt_q <= fcnt_d;
    end
  end
endmodule

// File: rtl/i2s_cfg_regs.sv
module i2s_cfg_regs
  import i2s_clkgen_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              fmt_open,
  input  logic              stop_evt,
  input  logic              match_evt,
  input  logic [CNT_W-1:0]  frame_cnt,
  output logic [DATA_W-1:0] rdata,
  output logic [4:0]        mclk_code,
  output logic [3:0]        sclk_code,
  output logic              master,
  output logic [2:0]        framing,
  output logic [CNT_W-1:0]  match_val,
  output logic              fcnt_wr,
  output logic [CNT_W-1:0]  fcnt_wdata,
  output logic              stop_flag,
  output logic              match_flag
);
  logic [DATA_W-1:0] fmt_q, fmt_d;
  logic [DATA_W-1:0] wsz_q, wsz_d;
  logic [CNT_W-1:0]  mv_q, mv_d;
  logic              stop_q, stop_d;
  logic              mtch_q, mtch_d;
  logic              wr_stat;

  assign wr_stat    = wr & (addr == A_STATUS);
  assign fcnt_wr    = wr & (addr == A_FCOUNT);
  assign fcnt_wdata = wdata[CNT_W-1:0];

  always_comb begin
    fmt_d = fmt_q;
    if (wr && addr == A_FORMAT && fmt_open)
      fmt_d = wdata & FORMAT_MASK;
    wsz_d = wsz_q;
    if (wr && addr == A_WSIZE)
      wsz_d = wdata & WSIZE_MASK;
    mv_d = mv_q;
    if (wr && addr == A_FMATCH)
      mv_d = wdata[CNT_W-1:0];
    stop_d = stop_evt  | (stop_q & ~(wr_stat & wdata[STAT_STOP_BIT]));
    mtch_d = match_evt | (mtch_q & ~(wr_stat & wdata[STAT_MATCH_BIT]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_q  <= '0;
      wsz_q  <= '0;
      mv_q   <= '0;
      stop_q <= 1'b0;
      mtch_q <= 1'b0;
    end else begin
      fmt_q  <= fmt_d;
      wsz_q  <= wsz_d;
      mv_q   <= mv_d;
      stop_q <= stop_d;
      mtch_q <= mtch_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_STATUS: begin
        rdata[STAT_STOP_BIT]  = stop_q;
        rdata[STAT_MATCH_BIT] = mtch_q;
      end
      A_FORMAT: rdata = fmt_q;
      A_FCOUNT: rdata = DATA_W'(frame_cnt);
      A_FMATCH: rdata = DATA_W'(mv_q);
      A_WSIZE:  rdata = wsz_q;
      default:  rdata = '0;
    endcase
  end

  assign mclk_code  = fmt_q[28:24];
  assign sclk_code  = fmt_q[23:20];
  assign master     = fmt_q[19];
  assign framing    = fmt_q[18:16];
  assign match_val  = mv_q;
  assign stop_flag  = stop_q;
  assign match_flag = mtch_q;
endmodule

// File: rtl/i2s_clkgen.sv
module i2s_clkgen
  import i2s_clkgen_pkg::*;
#(
  parameter int FCNT_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clk_run,
  input  logic        reg_wr,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mclk_en,
  output logic        sclk_en,
  output logic        lrclk,
  output logic        port_drive,
  output logic        irq
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = sync_q[SYNC_STAGES-1];

  logic              active_q, active_d;
  logic              stop_evt, fmt_open;
  logic [4:0]        mclk_code;
  logic [3:0]        sclk_code;
  logic              master;
  logic [2:0]        framing;
  logic [FCNT_W-1:0] match_val, frame_cnt, fcnt_wdata;
  logic              fcnt_wr, stop_flag, match_flag, match_hit;
  logic              mtick, stick, lr_int, frame_end;

  assign stop_evt = active_q & frame_end & ~clk_run;
  assign fmt_open = ~active_q & ~clk_run;

  always_comb begin
    active_d = active_q;
    if (active_q) begin
      if (stop_evt) active_d = 1'b0;
    end else if (clk_run) begin
      active_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) active_q <= 1'b0;
    else             active_q <= active_d;
  end

  i2s_cfg_regs #(.CNT_W(FCNT_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr         (reg_wr),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .fmt_open   (fmt_open),
    .stop_evt   (stop_evt),
    .match_evt  (match_hit),
    .frame_cnt  (frame_cnt),
    .rdata      (reg_rdata),
    .mclk_code  (mclk_code),
    .sclk_code  (sclk_code),
    .master     (master),
    .framing    (framing),
    .match_val  (match_val),
    .fcnt_wr    (fcnt_wr),
    .fcnt_wdata (fcnt_wdata),
    .stop_flag  (stop_flag),
    .match_flag (match_flag)
  );

  i2s_tick_div #(.W(MDIV_W)) u_mdiv (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .run      (active_q),
    .tick_in  (1'b1),
    .divisor  (mclk_divisor(mclk_code)),
    .tick_out (mtick)
  );

  i2s_tick_div #(.W(SDIV_W)) u_sdiv (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .run      (active_q),
    .tick_in  (mtick),
    .divisor  (sclk_divisor(sclk_code)),
    .tick_out (stick)
  );

  i2s_frame_seq #(.CNT_W(FCNT_W)) u_frame (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .run       (active_q),
    .bit_tick  (stick),
    .bpf       (bits_per_frame(framing)),
    .cnt_wr    (fcnt_wr),
    .cnt_wdata (fcnt_wdata),
    .match_val (match_val),
    .lrclk     (lr_int),
    .frame_end (frame_end),
    .frame_cnt (frame_cnt),
    .match_hit (match_hit)
  );

  assign mclk_en    = mtick;
  assign port_drive = master;
  assign sclk_en    = master & stick;
  assign lrclk      = master & lr_int;
  assign irq        = stop_flag | match_flag;
endmodule

// File: rtl/i2s_clkgen_chk.sv
module i2s_clkgen_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clk_run,
  input logic             active,
  input logic [12:0]      fmt_fields,
  input logic             stop_flag,
  input logic             match_flag,
  input logic [CNT_W-1:0] frame_cnt,
  input logic [CNT_W-1:0] match_val,
  input logic             mclk_en,
  input logic             sclk_en,
  input logic             lrclk,
  input logic             port_drive
);
  // R9: the format cannot move while a run is requested
  a_r9_format_locked: assert property (@(posedge clk) disable iff (!rst_n)
    clk_run |=> $stable(fmt_fields));

  // R8: stop flag appears exactly as the generator halts
  a_r8_stop_on_halt: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_flag) |-> ($past(active) && !active));

  // R8: no master-clock strobe while halted
  a_r8_quiet_when_halted: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !mclk_en);

  // R5: slave mode drives no bit or word clock
  a_r5_slave_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !port_drive |-> (!sclk_en && !lrclk));

  // R7: match flag rises only with counter on the match value
  a_r7_match_value: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(match_flag) |-> (frame_cnt == match_val));

  // R4: word select only moves after a bit-clock strobe
  a_r4_lr_on_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && port_drive && $past(port_drive) && !$past(sclk_en))
      |-> $stable(lrclk));
endmodule

bind i2s_clkgen i2s_clkgen_chk #(.CNT_W(FCNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clk_run    (clk_run),
  .active     (active_q),
  .fmt_fields ({mclk_code, sclk_code, master, framing}),
  .stop_flag  (stop_flag),
  .match_flag (match_flag),
  .frame_cnt  (frame_cnt),
  .match_val  (match_val),
  .mclk_en    (mclk_en),
  .sclk_en    (sclk_en),
  .lrclk      (lrclk),
  .port_drive (port_drive)
);

// File: tb/sim_i2s_clkgen.sv
`timescale 1ns/1ps
module sim_i2s_clkgen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clk_run = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        mclk_en, sclk_en, lrclk, port_drive, irq;

  int errors = 0;
  int checks = 0;
  bit running = 0;
  bit done = 0;

  always #10 clk = ~clk;

  i2s_clkgen u0 (
    .clk(clk), .rst_n(rst_n), .clk_run(clk_run), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mclk_en(mclk_en), .sclk_en(sclk_en), .lrclk(lrclk),
    .port_drive(port_drive), .irq(irq)
  );

  function automatic logic [31:0] fmtw(input int osc, input int m, input int s,
                                       input int ms, input int fr);
    fmtw = (32'(osc) << 30) | (32'(m) << 24) | (32'(s) << 20) |
           (32'(ms) << 19) | (32'(fr) << 16);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic halt();
    logic [31:0] s;
    int k;
    clk_run = 1'b0;
    if (running) begin
      k = 0;
      rd(8'h00, s);
      while (!s[24] && k < 20000) begin
        @(negedge clk); k++; rd(8'h00, s);
      end
      wr(8'h00, 32'h0100_0001);
    end
    running = 0;
  endtask

  task automatic start();
    @(negedge clk);
    clk_run = 1'b1;
    running = 1;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic setup(input logic [31:0] f);
    halt();
    wr(8'h10, f);
    start();
  endtask

  task automatic gap(input bit use_sclk, output int n);
    int k;
    k = 0;
    while (!(use_sclk ? sclk_en : mclk_en) && k < 1000) begin @(negedge clk); k++; end
    n = 0;
    do begin @(negedge clk); n++; end
    while (!(use_sclk ? sclk_en : mclk_en) && n < 1000);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(8'h00, v); chk("R1 status", v, 0);
    rd(8'h10, v); chk("R1 format", v, 0);
    rd(8'h40, v); chk("R1 fcount", v, 0);
    rd(8'h50, v); chk("R1 fmatch", v, 0);
    rd(8'h60, v); chk("R1 wsize", v, 0);
    chk("R1 outputs", {27'b0, mclk_en, sclk_en, lrclk, port_drive, irq}, 0);
  endtask

  task automatic t_mclk();
    int codes[5] = '{14, 13, 12, 0, 3};
    int divs[5]  = '{1, 3, 5, 2, 8};
    int n;
    for (int i = 0; i < 5; i++) begin
      setup(fmtw(0, codes[i], 8, 1, 2));
      gap(1'b0, n);
      chk($sformatf("R2 mclk code %0d", codes[i]), n, divs[i]);
    end
  endtask

  task automatic t_sclk();
    int codes[4] = '{8, 9, 0, 2};
    int divs[4]  = '{1, 3, 2, 6};
    int n;
    for (int i = 0; i < 4; i++) begin
      setup(fmtw(0, 14, codes[i], 1, 2));
      gap(1'b1, n);
      chk($sformatf("R3 sclk code %0d", codes[i]), n, divs[i]);
    end
    setup(fmtw(0, 13, 9, 1, 2));
    gap(1'b1, n);
    chk("R3 sclk 3x3", n, 9);
  endtask

  task automatic lr_runs(output int hi, output int lo);
    int k;
    k = 0;
    while (lrclk && k < 500) begin @(negedge clk); k++; end
    while (!lrclk && k < 1000) begin @(negedge clk); k++; end
    hi = 0;
    while (lrclk && hi < 500) begin @(negedge clk); hi++; end
    lo = 0;
    while (!lrclk && lo < 500) begin @(negedge clk); lo++; end
  endtask

  task automatic t_frame();
    int hi, lo;
    setup(fmtw(0, 14, 8, 1, 2));
    lr_runs(hi, lo);
    chk("R4 32-bit high half", hi, 16);
    chk("R4 32-bit low half", lo, 16);
    setup(fmtw(0, 14, 8, 1, 1));
    lr_runs(hi, lo);
    chk("R4 64-bit high half", hi, 32);
    chk("R4 64-bit low half", lo, 32);
  endtask

  task automatic t_slave();
    int seen_s, seen_lr, seen_m;
    seen_s = 0; seen_lr = 0; seen_m = 0;
    setup(fmtw(0, 14, 8, 0, 2));
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      seen_s += sclk_en; seen_lr += lrclk; seen_m += mclk_en;
    end
    chk("R5 slave no sclk", seen_s, 0);
    chk("R5 slave no lrclk", seen_lr, 0);
    chk("R5 slave port_drive", port_drive, 0);
    chk("R5 slave mclk runs", seen_m > 0, 1);
  endtask

  task automatic t_format_lock();
    logic [31:0] v;
    setup(fmtw(0, 14, 8, 1, 2));
    wr(8'h10, fmtw(1, 3, 3, 0, 0));
    rd(8'h10, v);
    chk("R9 format ignored while running", v, fmtw(0, 14, 8, 1, 2));
  endtask

  task automatic t_match();
    logic [31:0] v;
    int n;
    halt();
    wr(8'h10, fmtw(0, 14, 8, 1, 2));
    wr(8'h40, 32'd7);
    rd(8'h40, v); chk("R6 fcount load", v, 7);
    wr(8'h40, 32'd0);
    wr(8'h50, 32'd3);
    @(negedge clk);
    clk_run = 1'b1; running = 1;
    n = 0;
    while (!irq && n < 2000) begin @(negedge clk); n++; end
    chk("R7 irq after three frames", (n >= 96 && n <= 98), 1);
    rd(8'h40, v); chk("R6 fcount three frames", v, 3);
    rd(8'h00, v); chk("R7 match flag", v, 32'h1);
    wr(8'h00, 32'h1);
    rd(8'h00, v); chk("R7 match w1c", v, 0);
    chk("R7 irq cleared", irq, 0);
  endtask

  task automatic t_stop();
    logic [31:0] v;
    int n, m;
    setup(fmtw(0, 14, 8, 1, 2));
    clk_run = 1'b0;
    n = 0;
    rd(8'h00, v);
    while (!v[24] && n < 2000) begin @(negedge clk); n++; rd(8'h00, v); end
    chk("R8 stop within a frame", n <= 33, 1);
    chk("R8 irq on stop", irq, 1);
    m = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); m += mclk_en; end
    chk("R8 mclk halted", m, 0);
    wr(8'h00, 32'h0100_0000);
    rd(8'h00, v); chk("R8 stop w1c", v, 0);
    running = 0;
  endtask

  task automatic t_masks();
    logic [31:0] v;
    int n;
    halt();
    wr(8'h60, 32'hFFFF_FFFF);
    rd(8'h60, v); chk("R10 wsize mask", v, 32'h0303_0303);
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, v); chk("R10 format mask", v, 32'hDFFF_0000);
    setup(fmtw(2, 13, 8, 1, 2));
    gap(1'b0, n);
    chk("R10 oscillator no effect", n, 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_format_lock();
    t_mclk();
    t_sclk();
    t_frame();
    t_slave();
    t_match();
    t_stop();
    t_masks();
    halt();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule